// File: doc/BRIEF.md
# Transmit interrupt cause unit

This block raises the transmit-side interrupt causes of a network controller that walks a ring of descriptors. It watches the ring's head and tail pointers and the stream of descriptor write-back events, and it holds two sticky cause bits. Bit 0 is descriptor-done. Bit 1 is queue-empty. A single registered interrupt line is driven from those bits after a per-bit mask.

A write-back event carries two flags: a report-status flag and a delay-enable flag. A write-back with report-status alone sets descriptor-done at once. A write-back with both flags set does not set the bit at once. Instead it loads a countdown with the supplied interval, and the same descriptor-done bit is set when the countdown runs out. This lets software that adds packets one at a time receive one late interrupt rather than one per packet.

Software reads the cause bits on a read port and clears them by writing ones to a clear port.

Top module: `txint_cause_top`

## Requirements
- R1: While `rst_n` is low, `cause_o` is 0, `irq_o` is 0 and the countdown is idle.
- R2: A clock edge with `wb_valid`, `wb_rs` set and `wb_ide` clear sets `cause_o[0]` (descriptor-done) on that edge. The countdown is left unchanged.
- R3: A write-back with `wb_rs` clear changes neither the cause bits nor the countdown.
- R4: A write-back with both `wb_rs` and `wb_ide` set does not set `cause_o[0]` on its own edge. It loads the countdown with `delay_ival` = D. If nothing reloads the countdown, `cause_o[0]` is set on the (D+1)-th edge after the loading edge.
- R5: A new qualifying write-back while the countdown runs reloads it with the current `delay_ival`, so the delay restarts. A reload on the edge that would have expired the countdown wins, and no cause is set on that edge.
- R6: With `delay_ival` = 0, `cause_o[0]` is set on the edge after the loading edge.
- R7: `cause_o[1]` (queue-empty) is set on the edge where `head_ptr == tail_ptr` becomes true after being false. It is not set again while the pointers stay equal. The pointers are taken as equal out of reset.
- R8: Cause bits are sticky. An edge with `clr_valid` clears each bit whose `clr_bits` position is 1. When a set and a clear of the same bit fall on the same edge, the set wins.
- R9: `irq_o` equals the OR over i of (`cause_o[i]` AND `irq_mask[i]`), taken one edge earlier. The delayed descriptor-done is gated by `irq_mask[0]`, the same mask bit as the immediate one.
- R10: `cause_o` always shows the current state of the two cause bits, with bit 0 = descriptor-done and bit 1 = queue-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| head_ptr | input | PTR_W | Ring head pointer (hardware progress) |
| tail_ptr | input | PTR_W | Ring tail pointer (software fill level) |
| wb_valid | input | 1 | A descriptor write-back occurs this cycle |
| wb_rs | input | 1 | Report-status flag of that descriptor |
| wb_ide | input | 1 | Delay-enable flag of that descriptor |
| delay_ival | input | DLY_W | Countdown reload interval |
| irq_mask | input | 2 | Per-cause enable for the interrupt line |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_bits | input | 2 | Cause bits to clear |
| cause_o | output | 2 | Cause bits: [0] descriptor-done, [1] queue-empty |
| irq_o | output | 1 | Registered masked interrupt |

## Verification
The queue-empty property assumes the pointers are equal while reset is held, matching the reset value of the internal equality history; the bench holds both pointers at zero through reset. The zero-delay property assumes no qualifying write-back on the edge right after the loading one, and the bench leaves idle cycles after every delayed load so that this holds. The flags `wb_rs` and `wb_ide` are assumed to matter only when `wb_valid` is high. The stimulus drives them with `wb_valid` low in one step, to show that nothing happens.

// File: rtl/txint_pkg.sv
package txint_pkg;
  localparam int unsigned CAUSE_N      = 2;
  localparam int unsigned CAUSE_DONE   = 0;
  localparam int unsigned CAUSE_QEMPTY = 1;
  typedef logic [CAUSE_N-1:0] cause_vec_t;
endpackage

// File: rtl/txint_qempty_det.sv
// Flags the cycle in which head and tail become equal.
module txint_qempty_det #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] head_i,
  input  logic [PTR_W-1:0] tail_i,
  output logic             rise_o
);
  logic eq_now;
  logic eq_q;
  logic eq_d;

  always_comb begin
    eq_now = (head_i == tail_i);
    eq_d   = eq_now;
    rise_o = eq_now & ~eq_q;
  end

  // Reset value 1: an empty ring out of reset is not an event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b1;
    else        eq_q <= eq_d;
  end
endmodule

// File: rtl/txint_delay_timer.sv
// Countdown for the delayed descriptor-done cause.
module txint_delay_timer #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] ival_i,
  output logic             expire_o
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             cnt_zero;
  logic             en;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    expire_o = act_q & cnt_zero & ~load_i;
    en       = load_i | act_q;
    cnt_d    = cnt_q;
    act_d    = act_q;
    if (load_i) begin
      cnt_d = ival_i;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_zero) act_d = 1'b0;
      else          cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/txint_cause_reg.sv
// Sticky cause bits, write-one-to-clear, set has priority.
module txint_cause_reg #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] cause_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q, d, en;
    always_comb begin
      en = set_i[i] | clr_i[i];
      d  = set_i[i] | (q & ~clr_i[i]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end
    assign cause_o[i] = q;
  end
endmodule

// File: rtl/txint_irq_out.sv
// Registered masked OR of the cause bits.
module txint_irq_out #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cause_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic irq_d, irq_q;

  always_comb irq_d = |(cause_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/txint_cause_top.sv
module txint_cause_top
  import txint_pkg::*;
#(
  parameter int unsigned PTR_W = 8,
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] head_ptr,
  input  logic [PTR_W-1:0] tail_ptr,
  input  logic             wb_valid,
  input  logic             wb_rs,
  input  logic             wb_ide,
  input  logic [DLY_W-1:0] delay_ival,
  input  logic [1:0]       irq_mask,
  input  logic             clr_valid,
  input  logic [1:0]       clr_bits,
  output logic [1:0]       cause_o,
  output logic             irq_o
);
  logic       qe_rise;
  logic       dly_load;
  logic       dly_expire;
  cause_vec_t set_vec;
  cause_vec_t clr_vec;
  cause_vec_t cause_q;

  always_comb begin
    dly_load              = wb_valid & wb_rs & wb_ide;
    set_vec               = '0;
    set_vec[CAUSE_DONE]   = (wb_valid & wb_rs & ~wb_ide) | dly_expire;
    set_vec[CAUSE_QEMPTY] = qe_rise;
    clr_vec               = clr_valid ? clr_bits : '0;
  end

  txint_qempty_det #(.PTR_W(PTR_W)) u_qe (
    .clk(clk), .rst_n(rst_n), .head_i(head_ptr), .tail_i(tail_ptr), .rise_o(qe_rise)
  );

  txint_delay_timer #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load_i(dly_load), .ival_i(delay_ival), .expire_o(dly_expire)
  );

  txint_cause_reg #(.N(CAUSE_N)) u_cause (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .cause_o(cause_q)
  );

  txint_irq_out #(.N(CAUSE_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .cause_i(cause_q), .mask_i(irq_mask), .irq_o(irq_o)
  );

  assign cause_o = cause_q;
endmodule

// File: rtl/txint_cause_chk.sv
module txint_cause_chk #(
  parameter int unsigned PTR_W = 8,
  parameter int unsigned DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W-1:0] head_ptr,
  input logic [PTR_W-1:0] tail_ptr,
  input logic             wb_valid,
  input logic             wb_rs,
  input logic             wb_ide,
  input logic [DLY_W-1:0] delay_ival,
  input logic [1:0]       irq_mask,
  input logic             clr_valid,
  input logic [1:0]       clr_bits,
  input logic [1:0]       cause_o,
  input logic             irq_o
);
  logic past_ok;
  logic ptr_eq;

  assign ptr_eq = (head_ptr == tail_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (cause_o == 2'b00) && !irq_o);

  a_r2_done_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_rs && !wb_ide) |=> cause_o[0]);

  a_r6_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_rs && wb_ide && delay_ival == '0)
      ##1 !(wb_valid && wb_rs && wb_ide) |=> cause_o[0]);

  a_r7_qempty_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(ptr_eq)) |=> cause_o[1]);

  a_r8_sticky_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o[0] && !(clr_valid && clr_bits[0])) |=> cause_o[0]);

  a_r8_sticky_qempty: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o[1] && !(clr_valid && clr_bits[1])) |=> cause_o[1]);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> (irq_o == $past(|(cause_o & irq_mask))));
endmodule

bind txint_cause_top txint_cause_chk #(.PTR_W(PTR_W), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
  .wb_valid(wb_valid), .wb_rs(wb_rs), .wb_ide(wb_ide), .delay_ival(delay_ival),
  .irq_mask(irq_mask), .clr_valid(clr_valid), .clr_bits(clr_bits),
  .cause_o(cause_o), .irq_o(irq_o)
);

// File: tb/txint_cause_top_bench.sv
module txint_cause_top_bench;
  localparam int PTR_W = 8;
  localparam int DLY_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PTR_W-1:0] head_ptr = '0;
  logic [PTR_W-1:0] tail_ptr = '0;
  logic             wb_valid = 1'b0, wb_rs = 1'b0, wb_ide = 1'b0;
  logic [DLY_W-1:0] delay_ival = '0;
  logic [1:0]       irq_mask = 2'b11;
  logic             clr_valid = 1'b0;
  logic [1:0]       clr_bits = 2'b00;
  logic [1:0]       cause_o;
  logic             irq_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  txint_cause_top #(.PTR_W(PTR_W), .DLY_W(DLY_W)) u_txint_cause_top (
    .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
    .wb_valid(wb_valid), .wb_rs(wb_rs), .wb_ide(wb_ide), .delay_ival(delay_ival),
    .irq_mask(irq_mask), .clr_valid(clr_valid), .clr_bits(clr_bits),
    .cause_o(cause_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [1:0] cause;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // Reference model state, built from the requirements
  logic [1:0]       m_cause;
  logic             m_eq;
  logic             m_act;
  logic [DLY_W-1:0] m_cnt;

  task automatic tick(input string tag);
    logic       load, expire, rise;
    logic [1:0] setv, clrv;
    exp_t e;
    load   = wb_valid && wb_rs && wb_ide;
    expire = m_act && (m_cnt == '0) && !load;
    rise   = (head_ptr == tail_ptr) && !m_eq;
    setv   = {rise, (wb_valid && wb_rs && !wb_ide) || expire};
    clrv   = clr_valid ? clr_bits : 2'b00;
    e.irq   = |(m_cause & irq_mask);
    e.cause = setv | (m_cause & ~clrv);
    e.tag   = tag;
    sb.push_back(e);
    m_cause = e.cause;
    m_eq    = (head_ptr == tail_ptr);
    if (load) begin
      m_cnt = delay_ival; m_act = 1'b1;
    end else if (m_act) begin
      if (m_cnt == '0) m_act = 1'b0;
      else m_cnt = m_cnt - 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    wb_valid = 1'b0; wb_rs = 1'b0; wb_ide = 1'b0; clr_valid = 1'b0; clr_bits = 2'b00;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  // Monitor: pops one expected item per edge, samples 2 ns after it
  always begin
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cause_o !== e.cause || irq_o !== e.irq) begin
        failures++;
        $display("FAIL %s cause actual=%b expected=%b irq actual=%b expected=%b",
                 e.tag, cause_o, e.cause, irq_o, e.irq);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    m_cause = 2'b00; m_eq = 1'b1; m_act = 1'b0; m_cnt = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (cause_o !== 2'b00 || irq_o !== 1'b0) begin
      failures++;
      $display("FAIL R1/R10 reset actual=%b/%b expected=00/0", cause_o, irq_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R1");

    // R2: immediate descriptor-done
    wb_valid = 1; wb_rs = 1; wb_ide = 0; tick("R2");
    idle(2, "R9");
    clr_valid = 1; clr_bits = 2'b01; tick("R8");
    idle(1, "R8");

    // R3: no report-status -> nothing; flags without valid -> nothing
    wb_valid = 1; wb_rs = 0; wb_ide = 1; delay_ival = 16'd1; tick("R3");
    wb_valid = 0; wb_rs = 1; wb_ide = 0; tick("R3");
    idle(5, "R3");

    // R4: delayed by D=3, set on 4th edge after load
    delay_ival = 16'd3;
    wb_valid = 1; wb_rs = 1; wb_ide = 1; tick("R4");
    idle(6, "R4");
    clr_valid = 1; clr_bits = 2'b01; tick("R8");

    // R5: reload restarts the countdown
    delay_ival = 16'd5;
    wb_valid = 1; wb_rs = 1; wb_ide = 1; tick("R5");
    idle(3, "R5");
    delay_ival = 16'd4;
    wb_valid = 1; wb_rs = 1; wb_ide = 1; tick("R5");
    idle(7, "R5");
    clr_valid = 1; clr_bits = 2'b01; tick("R8");

    // R5: reload on the would-be expiry edge
    delay_ival = 16'd1;
    wb_valid = 1; wb_rs = 1; wb_ide = 1; tick("R5");
    idle(1, "R5");
    delay_ival = 16'd2;
    wb_valid = 1; wb_rs = 1; wb_ide = 1; tick("R5");
    idle(5, "R5");
    clr_valid = 1; clr_bits = 2'b01; tick("R8");

    // R6: zero interval
    delay_ival = 16'd0;
    wb_valid = 1; wb_rs = 1; wb_ide = 1; tick("R6");
    idle(3, "R6");
    clr_valid = 1; clr_bits = 2'b01; tick("R8");

    // R7: queue-empty on transition into head == tail
    tail_ptr = 8'd4; tick("R7");
    for (int h = 1; h <= 4; h++) begin
      head_ptr = h[PTR_W-1:0]; tick("R7");
    end
    idle(2, "R7");
    clr_valid = 1; clr_bits = 2'b10; tick("R8");
    idle(4, "R7");

    // R9: masking, including the delayed path under mask bit 0
    irq_mask = 2'b10;
    wb_valid = 1; wb_rs = 1; wb_ide = 0; tick("R9");
    idle(2, "R9");
    irq_mask = 2'b01; idle(2, "R9");
    clr_valid = 1; clr_bits = 2'b01; tick("R9");
    irq_mask = 2'b00;
    delay_ival = 16'd2;
    wb_valid = 1; wb_rs = 1; wb_ide = 1; tick("R9");
    idle(4, "R9");
    irq_mask = 2'b01; idle(2, "R9");

    // R8: set and clear on the same edge, set wins; clear both bits
    tail_ptr = 8'd9; tick("R8");
    head_ptr = 8'd9;
    clr_valid = 1; clr_bits = 2'b11; tick("R8");
    wb_valid = 1; wb_rs = 1; wb_ide = 0;
    clr_valid = 1; clr_bits = 2'b01; tick("R8");
    clr_valid = 1; clr_bits = 2'b11; tick("R10");
    idle(3, "R10");

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule